// File: doc/BRIEF.md
# Redundant Word Serializer with Sync Override

This block turns a stream of parallel words into a serial bit stream on two redundant line outputs. A word is taken in on each word boundary. The boundary is marked by a one-cycle strobe on the bit clock, and the strobe repeats every `W` bit-clock cycles. The word then leaves the block least significant bit first, one bit per bit-clock cycle. A fixed pipeline latency of `LAT` bit-clock cycles runs from the capturing edge to the first bit on the line. Clock synthesis, analog drivers and termination sit outside this block. The bit clock and the boundary strobe both come in from outside.

A sync control lets the host replace the parallel data with an alternating pattern. The control is sampled only on word boundaries, so the pattern always starts and stops on a whole word. Each of the two outputs is a true/complement pair and has its own enable. A disabled output, or any output before the first word has reached the line, is held at a fixed parked level. In that level the true line is high and the complement line is low.

Top module: `wtx_top`

## Requirements
- R1: On a bit-clock edge where `word_stb` is high and `sync_req` is low, the value on `din` is captured as the next word. Values on `din` at any other edge have no effect on the line.
- R2: A captured word is sent on the line in the order bit 0, bit 1, up to bit W-1, one bit per bit-clock cycle. Words from consecutive boundaries follow each other with no gap.
- R3: If `sync_req` is high on a capturing edge, the word sent for that boundary is the alternating pattern with bit i equal to 1 for even i (0x5555 for W=16). The line therefore shows 1,0,1,0,... starting with 1.
- R4: The sync pattern repeats for every boundary at which `sync_req` is high. Data resumes at the first boundary where it is low. A `sync_req` pulse that does not cover a boundary edge changes nothing.
- R5: Bit 0 of a word captured at edge t is on the line in the cycle that follows edge t+LAT (LAT=20). Bit k follows edge t+LAT+k.
- R6: When both outputs are enabled they carry identical data. On an enabled, active output the complement line is always the inverse of the true line.
- R7: When its enable is low, an output drives true=1 and complement=0 at once, without waiting for a clock edge. The other output is not affected.
- R8: During reset, and after reset until bit 0 of the first captured word reaches the line, both outputs are parked (true=1, complement=0) whatever their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | One bit-clock cycle in every W, marks the word boundary edge |
| din | input | W | Parallel word, sampled on the boundary edge |
| sync_req | input | 1 | Replace data with the alternating pattern, sampled on the boundary edge |
| en_a | input | 1 | Enable for output A |
| en_b | input | 1 | Enable for output B |
| txa_p | output | 1 | Output A, true line |
| txa_n | output | 1 | Output A, complement line |
| txb_p | output | 1 | Output B, true line |
| txb_n | output | 1 | Output B, complement line |

## Verification
Any fault in the capture register, the shift register or the delay stages ends up as a wrong bit on the line. The line is compared every cycle against an independent model of the stream. A stuck bit or a bit-order error therefore shows within one word period of the faulty capture plus LAT cycles. A delay line one stage too long or too short shifts every bit by one. That shows in the first cycle where two adjacent line bits differ, and the alternating sync pattern guarantees such a cycle. A wrong valid flag shows as an early or late unpark around cycle LAT after the first boundary.

// File: rtl/wtx_pkg.sv
package wtx_pkg;

  // One differential line as a true/complement pair
  typedef struct packed {
    logic p;
    logic n;
  } line_t;

  // Bit i of the alternating sync word: 1 on even positions
  function automatic logic alt_bit(input int i);
    return (i % 2) == 0;
  endfunction

  // Parked pair when disabled or not yet carrying data
  function automatic line_t drive_line(input logic en, input logic vld, input logic b);
    line_t l;
    if (!en || !vld) begin
      l.p = 1'b1;
      l.n = 1'b0;
    end else begin
      l.p = b;
      l.n = ~b;
    end
    return l;
  endfunction

endpackage

// File: rtl/wtx_capture.sv
module wtx_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_stb,
  input  logic [W-1:0] din,
  input  logic         sync_req,
  output logic [W-1:0] cap_word,
  output logic         cap_evt
);
  logic [W-1:0] sync_word;

  for (genvar i = 0; i < W; i++) begin : g_alt
    assign sync_word[i] = wtx_pkg::alt_bit(i);
  end

  // Input register; cap_evt marks the cycle after a capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_word <= '0;
      cap_evt  <= 1'b0;
    end else begin
      cap_evt <= word_stb;
      if (word_stb) cap_word <= sync_req ? sync_word : din;
    end
  end
endmodule

// File: rtl/wtx_shifter.sv
module wtx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic [W-1:0] shift_word,
  output logic         ser_bit,
  output logic         ser_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_word <= '0;
      ser_vld    <= 1'b0;
    end else begin
      if (load) shift_word <= word;
      else      shift_word <= {1'b0, shift_word[W-1:1]};
      ser_vld <= ser_vld | load;
    end
  end

  assign ser_bit = shift_word[0];
endmodule

// File: rtl/wtx_delay.sv
module wtx_delay #(
  parameter int DEPTH = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  input  logic in_vld,
  output logic out_bit,
  output logic out_vld
);
  logic [DEPTH-1:0] pb;
  logic [DEPTH-1:0] pv;

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pb <= '0;
        pv <= '0;
      end else begin
        pb <= in_bit;
        pv <= in_vld;
      end
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pb <= '0;
        pv <= '0;
      end else begin
        pb <= {pb[DEPTH-2:0], in_bit};
        pv <= {pv[DEPTH-2:0], in_vld};
      end
    end
  end

  assign out_bit = pb[DEPTH-1];
  assign out_vld = pv[DEPTH-1];
endmodule

// File: rtl/wtx_top.sv
module wtx_top #(
  parameter int W   = 16,
  parameter int LAT = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_stb,
  input  logic [W-1:0] din,
  input  logic         sync_req,
  input  logic         en_a,
  input  logic         en_b,
  output logic         txa_p,
  output logic         txa_n,
  output logic         txb_p,
  output logic         txb_n
);
  import wtx_pkg::*;

  // One stage is the shift register itself; the rest is the delay line
  localparam int DLY = LAT - 1;

  logic [W-1:0] cap_word;
  logic         cap_evt;
  logic [W-1:0] shift_word;
  logic         ser_bit;
  logic         ser_vld;
  logic         line_bit;
  logic         line_vld;
  line_t        la;
  line_t        lb;

  wtx_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .din(din),
    .sync_req(sync_req), .cap_word(cap_word), .cap_evt(cap_evt)
  );

  wtx_shifter #(.W(W)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(cap_evt), .word(cap_word),
    .shift_word(shift_word), .ser_bit(ser_bit), .ser_vld(ser_vld)
  );

  wtx_delay #(.DEPTH(DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_bit(ser_bit), .in_vld(ser_vld),
    .out_bit(line_bit), .out_vld(line_vld)
  );

  always_comb begin
    la = drive_line(en_a, line_vld, line_bit);
    lb = drive_line(en_b, line_vld, line_bit);
  end

  assign txa_p = la.p;
  assign txa_n = la.n;
  assign txb_p = lb.p;
  assign txb_n = lb.n;
endmodule

// File: rtl/wtx_chk.sv
module wtx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         word_stb,
  input logic         sync_req,
  input logic [W-1:0] din,
  input logic         en_a,
  input logic         en_b,
  input logic         cap_evt,
  input logic [W-1:0] cap_word,
  input logic [W-1:0] shift_word,
  input logic         line_vld,
  input logic         txa_p,
  input logic         txa_n,
  input logic         txb_p,
  input logic         txb_n
);
  localparam logic [W-1:0] ALT = {(W/2){2'b01}};

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && !sync_req |=> cap_word == $past(din));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(cap_word));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> shift_word == $past(cap_word));

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> shift_word == ($past(shift_word) >> 1));

  p_sync_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb && sync_req |=> cap_word == ALT);

  p_same_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_a && en_b |-> (txa_p == txb_p) && (txa_n == txb_n));

  p_pair_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_a && line_vld |-> txa_p != txa_n);

  p_park_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |-> txa_p && !txa_n);

  p_park_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b |-> txb_p && !txb_n);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_vld |-> txa_p && !txa_n && txb_p && !txb_n);

  p_vld_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld |=> line_vld);
endmodule

bind wtx_top wtx_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .sync_req(sync_req),
  .din(din), .en_a(en_a), .en_b(en_b), .cap_evt(cap_evt),
  .cap_word(cap_word), .shift_word(shift_word), .line_vld(line_vld),
  .txa_p(txa_p), .txa_n(txa_n), .txb_p(txb_p), .txb_n(txb_n)
);

// File: tb/sim_wtx_top.sv
module sim_wtx_top;
  localparam int CLK_T = 10;
  localparam int W     = 16;
  localparam int LAT   = 20;
  localparam int RING  = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         word_stb = 1'b0;
  logic [W-1:0] din = '0;
  logic         sync_req = 1'b0;
  logic         en_a = 1'b0;
  logic         en_b = 1'b0;
  logic         txa_p, txa_n, txb_p, txb_n;

  int ncheck = 0;
  int nbad = 0;
  int cyc = 0;
  int first_cap = -1;
  logic exp_bit [RING];
  logic exp_syn [RING];

  wtx_top #(.W(W), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .din(din),
    .sync_req(sync_req), .en_a(en_a), .en_b(en_b),
    .txa_p(txa_p), .txa_n(txa_n), .txb_p(txb_p), .txb_n(txb_n)
  );

  always #(CLK_T/2) clk = ~clk;

  // Word the requirements say goes out for a boundary (R1, R3)
  function automatic logic [W-1:0] model_word(input logic s, input logic [W-1:0] d);
    logic [W-1:0] w;
    if (!s) return d;
    for (int i = 0; i < W; i++) w[i] = ~i[0];
    return w;
  endfunction

  // Model the line timeline: bit k of a word caught at edge c follows edge c+LAT+k
  always @(posedge clk) begin
    logic [W-1:0] w;
    cyc = cyc + 1;
    if (rst_n && word_stb) begin
      w = model_word(sync_req, din);
      if (first_cap < 0) first_cap = cyc;
      for (int k = 0; k < W; k++) begin
        exp_bit[(cyc + LAT + k) % RING] = w[k];
        exp_syn[(cyc + LAT + k) % RING] = sync_req;
      end
    end
  end

  task automatic check_pair(input string nm, input logic en, input logic p, input logic n);
    logic vld, ep, en_x;
    string tag;
    vld = rst_n && first_cap >= 0 && cyc >= first_cap + LAT;
    if (!en) begin
      ep = 1'b1; en_x = 1'b0; tag = "R7";
    end else if (!vld) begin
      ep = 1'b1; en_x = 1'b0; tag = "R8";
    end else begin
      ep = exp_bit[cyc % RING]; en_x = ~ep;
      tag = exp_syn[cyc % RING] ? "R3,R4" : "R1,R2,R5";
    end
    ncheck++;
    if (p !== ep || n !== en_x) begin
      nbad++;
      $display("FAIL %s line %s cyc=%0d: got p=%b n=%b expected p=%b n=%b",
               tag, nm, cyc, p, n, ep, en_x);
    end
  endtask

  task automatic check_lines();
    check_pair("A", en_a, txa_p, txa_n);
    check_pair("B", en_b, txb_p, txb_n);
    if (en_a && en_b) begin
      ncheck++;
      if (txa_p !== txb_p || txa_n !== txb_n) begin
        nbad++;
        $display("FAIL R6 cyc=%0d: A=%b%b B=%b%b expected equal",
                 cyc, txa_p, txa_n, txb_p, txb_n);
      end
    end
  endtask

  // One word period; noise drives din and sync_req between boundaries (R1, R4)
  task automatic run_word(input logic [W-1:0] w, input logic s, input bit noise, input bit en_rand);
    for (int ph = 0; ph < W; ph++) begin
      @(negedge clk);
      check_lines();
      word_stb = (ph == 0);
      if (ph == 0) begin
        din = w;
        sync_req = s;
      end else if (noise) begin
        din = W'($urandom);
        sync_req = ($urandom % 4) == 0;
      end else begin
        sync_req = 1'b0;
      end
      if (en_rand) begin
        if ($urandom % 50 == 0) en_a = ~en_a;
        if ($urandom % 50 == 0) en_b = ~en_b;
      end
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", ncheck, nbad);
  endtask

  initial begin
    #(CLK_T * 200000);
    ncheck++;
    nbad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic s;
    void'($urandom(32'd4711));
    #1 rst_n = 1'b0;
    en_a = 1'b1;
    en_b = 1'b1;
    // R8: parked during reset even when enabled
    repeat (4) begin
      @(negedge clk);
      check_lines();
    end
    rst_n = 1'b1;
    // R8, R2, R5: order and latency on single-bit words, quiet inputs
    run_word(16'h0001, 1'b0, 1'b0, 1'b0);
    run_word(16'h8000, 1'b0, 1'b0, 1'b0);
    run_word(16'hA5C3, 1'b0, 1'b0, 1'b0);
    // R3, R4: sync held for three boundaries, then data resumes on the boundary
    run_word(16'hFFFF, 1'b1, 1'b0, 1'b0);
    run_word(16'h0000, 1'b1, 1'b0, 1'b0);
    run_word(16'h1234, 1'b1, 1'b0, 1'b0);
    run_word(16'h0000, 1'b0, 1'b0, 1'b0);
    run_word(16'hFFFF, 1'b0, 1'b0, 1'b0);
    // R4, R1: sync glitches and din noise between boundaries have no effect
    run_word(16'h0F0F, 1'b0, 1'b1, 1'b0);
    run_word(16'hFFFF, 1'b0, 1'b1, 1'b0);
    // R7: one output off while the other keeps running
    en_a = 1'b0;
    run_word(16'h3C3C, 1'b0, 1'b0, 1'b0);
    en_a = 1'b1;
    en_b = 1'b0;
    run_word(16'hC3C3, 1'b1, 1'b0, 1'b0);
    en_b = 1'b1;
    // Random mix
    for (int i = 0; i < 300; i++) begin
      s = ($urandom % 3) == 0;
      run_word(W'($urandom), s, 1'b1, 1'b1);
    end
    en_a = 1'b1;
    en_b = 1'b1;
    // Drain the pipeline with checks
    run_word(16'h0000, 1'b0, 1'b0, 1'b0);
    run_word(16'h0000, 1'b0, 1'b0, 1'b0);
    report();
    $finish;
  end
endmodule